// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a local-oscillator event stream down to the comparison rate of a phase detector. Each input event arrives as a one-cycle enable on the system clock. The block emits one output pulse for every completed division cycle. A 2-bit mode selects how the division is done. The first choice is a plain 12-bit down counter. The second is a dual-modulus (divide by 17 or by 16) prescaler feeding a 4-bit swallow counter and a 12-bit main counter. The third is a divide-by-2 stage placed in front of that prescaler path.

The divisor word and the mode are sampled only when a cycle starts. Software can therefore rewrite them at any time without producing a short or long reference cycle. While standby is asserted, all counting stops and no pulses appear. The first enable after standby is released starts a fresh cycle from the current settings.

Top module: `swallow_divider`

## Requirements
- R1: After reset, `pulse_o` is 0 and stays 0 until an enable has started a cycle. Clocks without `en_i` never advance the division.
- R2: With mode 01 or 10, the ratio is n = `divisor_i` (16 bits). Bits 15:4 form the main count M and bits 3:0 the swallow count S. The prescaler divides by 17 for the first S main steps and by 16 for the remaining steps. The legal range of n is 528..65535.
- R3: With mode 00 (direct), the ratio is M = `divisor_i[15:4]`. The legal range is 16..4095.
- R4: With mode 00, `divisor_i[3:0]` has no effect on the ratio.
- R5: With mode 11, a divide-by-2 stage precedes the pulse-swallow path, so the ratio is 2n.
- R6: While `standby_i` is 1, `pulse_o` is 0 and no cycle advances. The first enable after release starts a new cycle, and the pulse follows after a full ratio of enables.
- R7: A change of `divisor_i` or `mode_i` during a cycle does not alter that cycle. It applies from the next cycle start.
- R8: `pulse_o` rises on the enable that completes a cycle and falls on the next enable. It changes on no other clock.
- R9: The enable that starts a cycle produces no pulse. The pulse comes exactly one ratio of enables after it, and the pulse-to-pulse spacing in steady state equals the ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | One-cycle strobe per local-oscillator event |
| standby_i | input | 1 | Stops counting and silences the output |
| mode_i | input | 2 | Division mode: 00 direct, 01/10 pulse swallow, 11 halved plus swallow |
| divisor_i | input | 16 | Division word; bits 15:4 main count, bits 3:0 swallow count |
| pulse_o | output | 1 | High for one enable period at the end of each cycle |

## Verification
The hardest case is a settings change that lands in the middle of a cycle. It must leave the running count alone and take effect only from the following cycle. The stimulus starts a cycle, advances it a known number of enables, and then rewrites the divisor or the mode. The bench then measures the remaining distance to the pulse and the full period after it. Sparse enables with idle clocks in between also show that the output and the count move only on enables.

// File: rtl/swd_pkg.sv
package swd_pkg;
  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'b00,
    MODE_SWALLOW  = 2'b01,
    MODE_SWALLOW2 = 2'b10,
    MODE_HALVED   = 2'b11
  } div_mode_e;

  function automatic logic uses_prescaler(div_mode_e m);
    return m != MODE_DIRECT;
  endfunction
endpackage

// File: rtl/swd_half_stage.sv
module swd_half_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic halve_i,
  input  logic restart_i,
  output logic sub_en_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ph_q <= 1'b0;
    else if (restart_i) ph_q <= 1'b0;
    else if (en_i)      ph_q <= ~ph_q;
  end

  // second of every two enables passes when halving
  assign sub_en_o = en_i & (~halve_i | ph_q);
endmodule

// File: rtl/swd_prescaler.sv
module swd_prescaler #(
  parameter int SWALLOW_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cnt_en_i,
  input  logic long_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int PW      = SWALLOW_W + 1;
  localparam int PRE_MOD = 2 ** SWALLOW_W;
  localparam logic [PW-1:0] TOP_LONG  = PW'(PRE_MOD);
  localparam logic [PW-1:0] TOP_SHORT = PW'(PRE_MOD - 1);

  logic [PW-1:0] cnt_q;
  logic          at_top;

  assign at_top = cnt_q == (long_i ? TOP_LONG : TOP_SHORT);
  assign tick_o = cnt_en_i & at_top;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (cnt_en_i)  cnt_q <= at_top ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/swd_cycle_counter.sv
module swd_cycle_counter #(
  parameter int SWALLOW_W = 4,
  parameter int MAIN_W    = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [SWALLOW_W-1:0] swallow_val_i,
  input  logic [MAIN_W-1:0]    main_val_i,
  input  logic                 step_i,
  output logic                 last_o,
  output logic                 swallow_nz_o,
  output logic [SWALLOW_W-1:0] swallow_q_o,
  output logic [MAIN_W-1:0]    main_q_o
);
  logic [SWALLOW_W-1:0] sw_q;
  logic [MAIN_W-1:0]    main_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q   <= '0;
      main_q <= '0;
    end else if (load_i) begin
      sw_q   <= swallow_val_i;
      main_q <= main_val_i;
    end else if (step_i) begin
      main_q <= main_q - 1'b1;
      if (sw_q != '0) sw_q <= sw_q - 1'b1;
    end
  end

  assign last_o       = main_q == MAIN_W'(1);
  assign swallow_nz_o = sw_q != '0;
  assign swallow_q_o  = sw_q;
  assign main_q_o     = main_q;
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swd_pkg::*;
#(
  parameter int SWALLOW_W = 4,
  parameter int MAIN_W    = 12,
  localparam int DIV_W    = SWALLOW_W + MAIN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             standby_i,
  input  logic [1:0]       mode_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             pulse_o
);
  div_mode_e            act_mode;
  div_mode_e            next_mode;
  logic                 run_q;
  logic                 live_en, sub_en, pre_tick, step;
  logic                 start, end_evt, restart;
  logic                 last, sw_nz;
  logic [SWALLOW_W-1:0] sw_load, sw_cnt;
  logic [MAIN_W-1:0]    main_cnt;

  assign next_mode = div_mode_e'(mode_i);
  assign live_en   = run_q & ~standby_i & en_i;
  assign start     = en_i & ~standby_i & ~run_q;
  assign step      = uses_prescaler(act_mode) ? pre_tick : sub_en;
  assign end_evt   = step & last;
  assign restart   = start | end_evt;
  assign sw_load   = uses_prescaler(next_mode) ? divisor_i[SWALLOW_W-1:0] : '0;

  swd_half_stage u_half (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (live_en),
    .halve_i   (act_mode == MODE_HALVED),
    .restart_i (restart),
    .sub_en_o  (sub_en)
  );

  swd_prescaler #(.SWALLOW_W(SWALLOW_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_en_i  (sub_en & uses_prescaler(act_mode)),
    .long_i    (sw_nz),
    .restart_i (restart),
    .tick_o    (pre_tick)
  );

  swd_cycle_counter #(.SWALLOW_W(SWALLOW_W), .MAIN_W(MAIN_W)) u_cnt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (restart),
    .swallow_val_i (sw_load),
    .main_val_i    (divisor_i[DIV_W-1:SWALLOW_W]),
    .step_i        (step),
    .last_o        (last),
    .swallow_nz_o  (sw_nz),
    .swallow_q_o   (sw_cnt),
    .main_q_o      (main_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      pulse_o  <= 1'b0;
      act_mode <= MODE_DIRECT;
    end else if (standby_i) begin
      run_q   <= 1'b0;
      pulse_o <= 1'b0;
    end else if (en_i) begin
      pulse_o <= end_evt;
      if (start) run_q <= 1'b1;
      if (restart) act_mode <= next_mode;
    end
  end
endmodule

// File: rtl/swd_checker.sv
module swd_checker #(
  parameter int SWALLOW_W = 4,
  parameter int MAIN_W    = 12
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 en_i,
  input logic                 standby_i,
  input logic                 pulse_o,
  input logic                 run_q,
  input logic [1:0]           act_mode,
  input logic [SWALLOW_W-1:0] sw_cnt,
  input logic [MAIN_W-1:0]    main_cnt
);
  p_standby_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> !pulse_o);

  p_hold_between_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !standby_i) |=> $stable(pulse_o));

  p_single_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pulse_o && !standby_i) |=> !pulse_o);

  // swallow phase must end before main count runs out
  p_swallow_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && act_mode != 2'b00 && sw_cnt != '0) |-> (main_cnt > MAIN_W'(sw_cnt)));

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !en_i) |=> !pulse_o);
endmodule

bind swallow_divider swd_checker #(.SWALLOW_W(SWALLOW_W), .MAIN_W(MAIN_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .standby_i (standby_i),
  .pulse_o   (pulse_o),
  .run_q     (run_q),
  .act_mode  (act_mode),
  .sw_cnt    (sw_cnt),
  .main_cnt  (main_cnt)
);

// File: tb/swallow_divider_bench.sv
module swallow_divider_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] div;
    logic [16:0] exp;
  } vec_t;

  // mode, divisor, expected ratio in enables
  localparam vec_t VEC [NV] = '{
    '{2'b00, 16'h0FF0, 17'd255},
    '{2'b00, 16'h0FFF, 17'd255},
    '{2'b00, 16'h0100, 17'd16},
    '{2'b00, 16'hFFF0, 17'd4095},
    '{2'b01, 16'h0210, 17'd528},
    '{2'b10, 16'h0A5F, 17'd2655},
    '{2'b01, 16'h1230, 17'd4656},
    '{2'b11, 16'h0210, 17'd1056},
    '{2'b11, 16'h0217, 17'd1070}
  };
  string tags [NV] = '{"R3", "R4", "R3", "R3", "R2", "R2", "R2", "R5", "R5"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        stby = 1'b1;
  logic [1:0]  mode = 2'b00;
  logic [15:0] div = 16'h0100;
  logic        pulse;

  int  checks = 0, errors = 0, gap = 0, hold_bad = 0, n = 0, pulses = 0;
  logic last_p = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  swallow_divider u_swallow_divider (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .en_i      (en),
    .standby_i (stby),
    .mode_i    (mode),
    .divisor_i (div),
    .pulse_o   (pulse)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    last_p = pulse;
    if (gap > 0) begin
      en = 1'b0;
      for (int i = 0; i < gap; i++) begin
        @(posedge clk);
        @(negedge clk);
        if (pulse !== last_p) hold_bad++;
      end
    end
  endtask

  task automatic count_to_pulse(input int limit, output int cnt);
    cnt = 0;
    do begin
      step();
      cnt++;
    end while (!last_p && cnt <= limit);
  endtask

  task automatic load(input logic [1:0] m, input logic [15:0] d);
    stby = 1'b1;
    step();
    mode = m;
    div  = d;
    stby = 1'b0;
    step();
    check(last_p == 1'b0, "R9 start enable pulse", last_p, 0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pulse == 1'b0, "R1 reset pulse", pulse, 0);
    rst_n = 1'b1;
    stby  = 1'b0;
    repeat (6) @(negedge clk);
    check(pulse == 1'b0, "R1 no enable no pulse", pulse, 0);

    for (int v = 0; v < NV; v++) begin
      load(VEC[v].mode, VEC[v].div);
      count_to_pulse(int'(VEC[v].exp) + 4, n);
      check(n == int'(VEC[v].exp), tags[v], n, VEC[v].exp);
      count_to_pulse(int'(VEC[v].exp) + 4, n);
      check(n == int'(VEC[v].exp), "R9 period", n, VEC[v].exp);
      step();
      check(last_p == 1'b0, "R8 pulse falls", last_p, 0);
    end

    // R6 standby stops the division
    load(2'b00, 16'h0100);
    repeat (5) step();
    stby = 1'b1;
    pulses = 0;
    for (int i = 0; i < 40; i++) begin
      step();
      if (last_p) pulses++;
    end
    check(pulses == 0, "R6 pulses in standby", pulses, 0);
    stby = 1'b0;
    step();
    check(last_p == 1'b0, "R6 restart enable", last_p, 0);
    count_to_pulse(40, n);
    check(n == 16, "R6 ratio after release", n, 16);

    // R7 divisor change mid-cycle
    load(2'b00, 16'h0640);
    repeat (10) step();
    div = 16'h0140;
    count_to_pulse(120, n);
    check(n == 90, "R7 old divisor holds", n, 90);
    count_to_pulse(120, n);
    check(n == 20, "R7 new divisor at reload", n, 20);

    // R7 mode change mid-cycle
    load(2'b00, 16'h0210);
    repeat (3) step();
    mode = 2'b01;
    count_to_pulse(600, n);
    check(n == 30, "R7 old mode holds", n, 30);
    count_to_pulse(600, n);
    check(n == 528, "R7 new mode at reload", n, 528);

    // R1 R8 sparse enables
    gap = 2;
    load(2'b00, 16'h0100);
    count_to_pulse(40, n);
    check(n == 16, "R1 idle clocks do not count", n, 16);
    step();
    check(last_p == 1'b0, "R8 falls on next enable", last_p, 0);
    gap = 0;
    check(hold_bad == 0, "R8 output moved between enables", hold_bad, 0);

    summary();
    $finish;
  end
endmodule